// File: doc/BRIEF.md
# I2C bus clock tick generator

This block turns a fast source clock into the bit timing of an I2C bus master. A prescaler divides the source clock by a programmable value. A step counter runs on the prescaled ticks, and a sample counter advances each time the step counter wraps. One full cycle of the sample counter is one half-period of the serial clock. The block drives the serial clock level and two one-cycle strobes: one at every serial-clock edge, and one in the middle of each high half-period, where a bit-level engine samples the data line.

Two timing sets are held. The standard/fast set times normal traffic and the master-code phase of a high-speed transfer. The high-speed set applies while the engine asserts the high-speed phase input, but only if its enable field is nonzero. Software works out the best count values and writes them. The block only applies them. It loads a new count, divider or phase selection only at a half-period boundary, so a change never shortens a half-period already under way.

Top module: `scl_tick_gen`

## Requirements
- R1: After reset the serial clock is high, both strobes are low, and every configuration register is zero, so that a run with no writes gives half-periods of one cycle.
- R2: While `run` is low, the serial clock is driven high, both strobes are low, and all counters are cleared one cycle later.
- R3: The standard/fast word (`wr_sel`=0) holds sample count minus one in bits [10:8] and step count minus one in bits [5:0]. Each half-period lasts D x T x S source cycles, where D is the divider, T the step count (1 to 64) and S the sample count (1 to 8).
- R4: The divider word (`wr_sel`=2) holds D minus one in bits [DIV_W-1:0]. The full range of D is applied.
- R5: The high-speed word (`wr_sel`=1) holds sample count minus one in bits [14:12], step count minus one (step count 1 to 8) in bits [10:8], and an enable code in bits [1:0]. When the enable code is nonzero and `hs_phase` is high, half-periods use this set.
- R6: When the high-speed enable code is zero, the standard/fast set is used even while `hs_phase` is high.
- R7: `phase_stb` is high for exactly one cycle, in the first cycle that shows each new serial-clock level.
- R8: `sample_stb` pulses once in each high half-period, D x T x (floor((S-1)/2)+1) cycles after the rising edge. It never pulses in a low half-period.
- R9: A register write or an `hs_phase` change made during a running half-period does not alter that half-period. It takes effect from the next one.
- R10: A write with `wr_sel`=3 changes no timing.
- R11: When `run` rises, the first half-period starts high and lasts the full configured length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 standard/fast, 1 high-speed, 2 divider, 3 none |
| wr_data | input | DATA_W | Register write data |
| run | input | 1 | Enable the timing counters |
| hs_phase | input | 1 | High-speed phase select from the bit engine |
| scl_out | output | 1 | Serial clock level |
| phase_stb | output | 1 | One-cycle pulse on every serial-clock edge |
| sample_stb | output | 1 | One-cycle pulse at the middle of the high half-period |

## Verification
Random divider, step and sample combinations are checked against the product D x T x S. Each multiplier is varied on its own, so a swapped field or a wrong nesting shows up as a wrong half-period length, and odd and even sample counts tell apart the floor used for the sample position. Directed cases push the step, sample and divider fields to their maximum, and use a sample count of one, where the sample strobe falls on the clock edge. Writes made and phase changes made mid-period show whether reloads wait for the boundary. High-speed words with a zero enable code, and writes with the unused select code, must leave the timing unchanged.

// File: rtl/scl_tick_pkg.sv
package scl_tick_pkg;

  localparam int SAMP_W     = 3;
  localparam int STD_STEP_W = 6;
  localparam int HS_STEP_W  = 3;
  localparam int HS_EN_W    = 2;

  localparam int STD_SAMP_LSB = 8;
  localparam int STD_STEP_LSB = 0;
  localparam int HS_SAMP_LSB  = 12;
  localparam int HS_STEP_LSB  = 8;
  localparam int HS_EN_LSB    = 0;

  typedef enum logic [1:0] {
    SEL_STD  = 2'd0,
    SEL_HS   = 2'd1,
    SEL_DIV  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [SAMP_W-1:0]     samp_lim;
    logic [STD_STEP_W-1:0] step_lim;
  } count_set_t;

endpackage

// File: rtl/scl_cfg_regs.sv
module scl_cfg_regs
  import scl_tick_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              hs_phase,
  output count_set_t        sel_set,
  output logic [DIV_W-1:0]  div_lim
);

  count_set_t            std_q, std_d;
  logic [SAMP_W-1:0]     hs_samp_q, hs_samp_d;
  logic [HS_STEP_W-1:0]  hs_step_q, hs_step_d;
  logic [HS_EN_W-1:0]    hs_en_q, hs_en_d;
  logic [DIV_W-1:0]      div_q, div_d;
  logic                  std_we, hs_we, div_we;

  assign std_we = wr_en && (reg_sel_e'(wr_sel) == SEL_STD);
  assign hs_we  = wr_en && (reg_sel_e'(wr_sel) == SEL_HS);
  assign div_we = wr_en && (reg_sel_e'(wr_sel) == SEL_DIV);

  always_comb begin
    std_d     = std_q;
    hs_samp_d = hs_samp_q;
    hs_step_d = hs_step_q;
    hs_en_d   = hs_en_q;
    div_d     = div_q;
    if (std_we) begin
      std_d.samp_lim = wr_data[STD_SAMP_LSB +: SAMP_W];
      std_d.step_lim = wr_data[STD_STEP_LSB +: STD_STEP_W];
    end
    if (hs_we) begin
      hs_samp_d = wr_data[HS_SAMP_LSB +: SAMP_W];
      hs_step_d = wr_data[HS_STEP_LSB +: HS_STEP_W];
      hs_en_d   = wr_data[HS_EN_LSB +: HS_EN_W];
    end
    if (div_we) begin
      div_d = wr_data[DIV_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      std_q     <= '0;
      hs_samp_q <= '0;
      hs_step_q <= '0;
      hs_en_q   <= '0;
      div_q     <= '0;
    end else begin
      std_q     <= std_d;
      hs_samp_q <= hs_samp_d;
      hs_step_q <= hs_step_d;
      hs_en_q   <= hs_en_d;
      div_q     <= div_d;
    end
  end

  // High-speed counts apply only in the high-speed phase with a nonzero enable code
  always_comb begin
    if (hs_phase && (hs_en_q != '0)) begin
      sel_set.samp_lim = hs_samp_q;
      sel_set.step_lim = STD_STEP_W'(hs_step_q);
    end else begin
      sel_set = std_q;
    end
  end

  assign div_lim = div_q;

endmodule

// File: rtl/scl_wrap_cnt.sv
module scl_wrap_cnt #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         adv,
  input  logic [W-1:0] lim,
  output logic [W-1:0] cnt,
  output logic         wrap
);

  logic [W-1:0] cnt_d;

  assign wrap = adv && (cnt == lim);

  always_comb begin
    cnt_d = cnt;
    if (clr)       cnt_d = '0;
    else if (wrap) cnt_d = '0;
    else if (adv)  cnt_d = cnt + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

endmodule

// File: rtl/scl_tick_gen.sv
module scl_tick_gen
  import scl_tick_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              run,
  input  logic              hs_phase,
  output logic              scl_out,
  output logic              phase_stb,
  output logic              sample_stb
);

  count_set_t          sel_set;
  logic [DIV_W-1:0]    sel_div;
  count_set_t          act_set, act_set_d;
  logic [DIV_W-1:0]    act_div, act_div_d;
  logic                load_act;

  logic [DIV_W-1:0]      pre_cnt;
  logic [STD_STEP_W-1:0] step_cnt;
  logic [SAMP_W-1:0]     samp_cnt;
  logic                  tick, step_wrap, half_end;
  logic                  cnt_clr;
  logic                  scl_d, phase_d, sample_d;
  logic                  mid_slot;

  scl_cfg_regs #(
    .DATA_W (DATA_W),
    .DIV_W  (DIV_W)
  ) cfg_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .hs_phase (hs_phase),
    .sel_set  (sel_set),
    .div_lim  (sel_div)
  );

  assign cnt_clr = !run;

  // Prescaler, step and sample counters form a chain of nested wrap counters
  scl_wrap_cnt #(.W(DIV_W)) pre_i (
    .clk (clk), .rst_n (rst_n), .clr (cnt_clr), .adv (run),
    .lim (act_div), .cnt (pre_cnt), .wrap (tick)
  );

  scl_wrap_cnt #(.W(STD_STEP_W)) step_i (
    .clk (clk), .rst_n (rst_n), .clr (cnt_clr), .adv (tick),
    .lim (act_set.step_lim), .cnt (step_cnt), .wrap (step_wrap)
  );

  scl_wrap_cnt #(.W(SAMP_W)) samp_i (
    .clk (clk), .rst_n (rst_n), .clr (cnt_clr), .adv (step_wrap),
    .lim (act_set.samp_lim), .cnt (samp_cnt), .wrap (half_end)
  );

  // Active timing follows the registers while idle, then reloads only at boundaries
  assign load_act = !run || half_end;

  always_comb begin
    act_set_d = act_set;
    act_div_d = act_div;
    if (load_act) begin
      act_set_d = sel_set;
      act_div_d = sel_div;
    end
  end

  assign mid_slot = (samp_cnt == (act_set.samp_lim >> 1));

  always_comb begin
    scl_d    = scl_out;
    phase_d  = 1'b0;
    sample_d = 1'b0;
    if (!run) begin
      scl_d = 1'b1;
    end else begin
      if (half_end) scl_d = !scl_out;
      phase_d  = half_end;
      sample_d = scl_out && step_wrap && mid_slot;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_set    <= '0;
      act_div    <= '0;
      scl_out    <= 1'b1;
      phase_stb  <= 1'b0;
      sample_stb <= 1'b0;
    end else begin
      act_set    <= act_set_d;
      act_div    <= act_div_d;
      scl_out    <= scl_d;
      phase_stb  <= phase_d;
      sample_stb <= sample_d;
    end
  end

endmodule

// File: rtl/scl_tick_gen_chk.sv
module scl_tick_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic run,
  input logic scl_out,
  input logic phase_stb,
  input logic sample_stb
);

  // R2
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (scl_out && !phase_stb && !sample_stb));

  // R7
  phase_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_stb |-> (scl_out != $past(scl_out)));

  // R7
  edge_marked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_out != $past(scl_out)) |-> (phase_stb || !$past(run)));

  // R8
  sample_in_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> $past(scl_out));

endmodule

bind scl_tick_gen scl_tick_gen_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .run        (run),
  .scl_out    (scl_out),
  .phase_stb  (phase_stb),
  .sample_stb (sample_stb)
);

// File: tb/scl_tick_gen_tb_top.sv
`timescale 1ns/1ps
module scl_tick_gen_tb_top;

  localparam int DATA_W = 16;
  localparam int DIV_W  = 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              wr_en;
  logic [1:0]        wr_sel;
  logic [DATA_W-1:0] wr_data;
  logic              run;
  logic              hs_phase;
  logic              scl_out, phase_stb, sample_stb;

  int checks = 0;
  int errors = 0;

  int div_s, st_t, st_s, hs_t, hs_s, hs_en;

  always #10 clk = !clk;

  scl_tick_gen #(.DATA_W(DATA_W), .DIV_W(DIV_W)) dut_i (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_sel (wr_sel),
    .wr_data (wr_data), .run (run), .hs_phase (hs_phase),
    .scl_out (scl_out), .phase_stb (phase_stb), .sample_stb (sample_stb)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_len(input bit hs);
    if (hs && hs_en != 0) return (div_s + 1) * hs_t * hs_s;
    return (div_s + 1) * st_t * st_s;
  endfunction

  function automatic int exp_off(input bit hs);
    if (hs && hs_en != 0) return (div_s + 1) * hs_t * (((hs_s - 1) >> 1) + 1);
    return (div_s + 1) * st_t * (((st_s - 1) >> 1) + 1);
  endfunction

  // Called at a negedge; the write lands on the next posedge
  task automatic wr(input int sel, input int data);
    wr_en   = 1'b1;
    wr_sel  = 2'(sel);
    wr_data = DATA_W'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_std(input int t, input int s);
    st_t = t; st_s = s;
    wr(0, ((s - 1) << 8) | (t - 1));
  endtask

  task automatic set_hs(input int t, input int s, input int en);
    hs_t = t; hs_s = s; hs_en = en;
    wr(1, ((s - 1) << 12) | ((t - 1) << 8) | en);
  endtask

  task automatic set_div(input int d);
    div_s = d;
    wr(2, d);
  endtask

  // Measures one half-period starting at the current negedge
  task automatic half(input int start_c, input int n_exp, input int off_exp, input string req);
    bit lvl = scl_out;
    int c = start_c;
    int spos = -1;
    int scnt = 0;
    int pcnt = 0;
    do begin
      @(negedge clk);
      c++;
      if (sample_stb) begin scnt++; spos = c; end
      if (phase_stb) pcnt++;
    end while (scl_out == lvl && c < 5000);
    chk(c == n_exp, {req, " half length"}, c, n_exp);
    chk(pcnt == 1 && phase_stb, "R7 phase strobe once at edge", pcnt, 1);
    if (lvl) begin
      chk(scnt == 1 && spos == off_exp, "R8 sample position", spos, off_exp);
    end else begin
      chk(scnt == 0, "R8 no sample in low half", scnt, 0);
    end
  endtask

  task automatic start_run();
    @(negedge clk);
    @(negedge clk);
    run = 1'b1;
  endtask

  task automatic stop_run();
    run = 1'b0;
    @(negedge clk);
    chk(scl_out && !phase_stb && !sample_stb, "R2 idle outputs", int'({scl_out, phase_stb, sample_stb}), 4);
    @(negedge clk);
    chk(scl_out && !phase_stb && !sample_stb, "R2 idle outputs held", int'({scl_out, phase_stb, sample_stb}), 4);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog act=0 exp=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0; run = 1'b0; hs_phase = 1'b0;
    div_s = 0; st_t = 1; st_s = 1; hs_t = 1; hs_s = 1; hs_en = 0;
    repeat (3) @(negedge clk);
    chk(scl_out && !phase_stb && !sample_stb, "R1 reset outputs", int'({scl_out, phase_stb, sample_stb}), 4);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: zero registers give one-cycle half-periods; R11 first half high
    start_run();
    chk(scl_out == 1'b1, "R11 starts high", scl_out, 1);
    half(0, 1, 1, "R1");
    half(0, 1, 0, "R1");
    stop_run();

    // R3 R4 R5 R6 random configurations
    for (int i = 0; i < 18; i++) begin
      bit hp;
      set_div($urandom_range(0, 2));
      set_std($urandom_range(1, 16), $urandom_range(1, 8));
      set_hs($urandom_range(1, 8), $urandom_range(1, 8), $urandom_range(0, 3));
      hp = 1'($urandom_range(0, 1));
      hs_phase = hp;
      start_run();
      half(0, exp_len(hp), exp_off(hp), "R3 R5 random");
      half(0, exp_len(hp), exp_off(hp), "R3 R5 random");
      half(0, exp_len(hp), exp_off(hp), "R3 R5 random");
      stop_run();
    end
    hs_phase = 1'b0;

    // R3: maximum step and sample counts
    set_div(0); set_std(64, 8);
    start_run();
    half(0, 512, 256, "R3 max fields");
    half(0, 512, 0, "R3 max fields");
    stop_run();

    // R4: maximum divider
    set_div(255); set_std(1, 1);
    start_run();
    half(0, 256, 256, "R4 max divider");
    stop_run();

    // R6: zero enable code keeps standard timing in high-speed phase
    set_div(1); set_std(3, 3); set_hs(7, 5, 0);
    hs_phase = 1'b1;
    start_run();
    half(0, 18, 12, "R6 hs disabled");
    half(0, 18, 0, "R6 hs disabled");
    stop_run();
    hs_phase = 1'b0;

    // R10: unused select leaves timing unchanged
    wr(3, 16'hFFFF);
    start_run();
    half(0, 18, 12, "R10 ignored write");
    stop_run();

    // R9: standard word rewritten mid half-period
    set_div(0); set_std(4, 2);
    start_run();
    half(0, 8, 4, "R9 before write");
    set_std(2, 1);
    half(1, 8, 0, "R9 old length kept");
    half(0, 2, 2, "R9 new length");
    stop_run();

    // R5 R9: high-speed phase switched mid half-period
    set_div(1); set_std(5, 1); set_hs(3, 2, 3);
    hs_phase = 1'b0;
    start_run();
    half(0, 10, 10, "R5 std phase");
    hs_phase = 1'b1;
    half(0, 10, 0, "R9 phase change deferred");
    half(0, 12, 6, "R5 hs timing");
    half(0, 12, 0, "R5 hs timing");
    stop_run();
    hs_phase = 1'b0;

    // R11: restart after a stop gives a full first half
    start_run();
    half(0, 10, 10, "R11 restart");
    stop_run();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule